// File: doc/BRIEF.md
# Stream Traffic Counter with Triggered Report

This block watches the handshake of one AXI4-Stream link without driving any of its signals. It accumulates two totals: the number of bytes carried and the number of frames completed. The bytes of a beat are the set keep bits. A beat counts only when its valid and ready are both high. A frame is complete on such a beat when its last flag is also high.

A single-cycle trigger pulse takes a snapshot of both totals together with a tag input. It restarts the totals in the same clock edge and starts sending the snapshot as a byte-wide AXI4-Stream report frame. Several monitors driven by one trigger can have their report frames combined downstream.

Top module: `stream_stat_mon`

## Requirements
- R1: After reset the report output is idle (valid and last low), and a report triggered before any traffic carries zero byte and frame counts.
- R2: Each beat with valid and ready both high adds the number of set keep bits to the byte total.
- R3: A beat with valid low or ready low adds nothing to either total.
- R4: Each beat with valid, ready and last all high adds one to the frame total.
- R5: A report is exactly 10 bytes: the 16-bit tag, then the 32-bit byte total, then the 32-bit frame total, each sent most significant byte first. Last is high on the tenth byte only, and valid drops after the tenth byte is accepted.
- R6: The trigger clears both totals in the same cycle it captures them. Traffic accepted in the trigger cycle belongs to the next report, not to the one being captured.
- R7: A trigger that arrives while a report is still being sent is ignored. It produces no extra report and clears nothing, so the next report includes all traffic since the last accepted trigger.
- R8: While the report consumer holds ready low, report data, valid and last stay unchanged.
- R9: Report valid is high in the cycle after an accepted trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mon_keep | input | KEEP_W | Keep bits of the monitored link |
| mon_valid | input | 1 | Valid of the monitored link |
| mon_ready | input | 1 | Ready of the monitored link |
| mon_last | input | 1 | Last flag of the monitored link |
| tag | input | TAG_W | Tag value placed at the head of each report |
| trigger | input | 1 | Capture, clear and report pulse |
| rpt_data | output | 8 | Report byte |
| rpt_valid | output | 1 | Report byte valid |
| rpt_ready | input | 1 | Report consumer ready |
| rpt_last | output | 1 | Final report byte |

## Verification
Mixed keep patterns are applied to the counter inputs (full, sparse, single-bit and empty). These are interleaved with cycles where only valid or only ready is high, so a miscount from a partial handshake shows up apart from a wrong popcount. A beat placed on the trigger cycle shows whether same-cycle traffic lands in the old or the new period. A burst of triggers and traffic while a stalled report is pending separates proper ignoring from a restart or lost counts. Alternating consumer stalls separate a correct hold from a skipped or repeated byte.

// File: rtl/stream_stat_mon.sv
module stream_stat_mon #(
  parameter int KEEP_W = 8,
  parameter int TAG_W  = 16,
  parameter int BCNT_W = 32,
  parameter int FCNT_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [KEEP_W-1:0] mon_keep,
  input  logic              mon_valid,
  input  logic              mon_ready,
  input  logic              mon_last,
  input  logic [TAG_W-1:0]  tag,
  input  logic              trigger,
  output logic [7:0]        rpt_data,
  output logic              rpt_valid,
  input  logic              rpt_ready,
  output logic              rpt_last
);

  localparam int REP_W     = TAG_W + BCNT_W + FCNT_W;
  localparam int REP_BYTES = REP_W / 8;
  localparam int IDX_W     = (REP_BYTES > 1) ? $clog2(REP_BYTES) : 1;
  localparam int KCNT_W    = $clog2(KEEP_W + 1);

  logic [BCNT_W-1:0] byte_cnt;
  logic [FCNT_W-1:0] frame_cnt;
  logic [REP_W-1:0]  shreg;
  logic [IDX_W-1:0]  idx;
  logic              busy;
  logic [KCNT_W-1:0] beat_bytes;

  always_comb begin
    beat_bytes = '0;
    for (int i = 0; i < KEEP_W; i++)
      beat_bytes = beat_bytes + KCNT_W'(mon_keep[i]);
  end

  wire               beat      = mon_valid & mon_ready;
  wire [BCNT_W-1:0]  add_bytes = beat ? BCNT_W'(beat_bytes) : '0;
  wire [FCNT_W-1:0]  add_frame = FCNT_W'(beat & mon_last);
  wire               fire      = trigger & ~busy;
  wire               is_last   = (idx == IDX_W'(REP_BYTES - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      byte_cnt  <= '0;
      frame_cnt <= '0;
      shreg     <= '0;
      idx       <= '0;
      busy      <= 1'b0;
    end else if (fire) begin
      byte_cnt  <= add_bytes;
      frame_cnt <= add_frame;
      shreg     <= {tag, byte_cnt, frame_cnt};
      idx       <= '0;
      busy      <= 1'b1;
    end else begin
      byte_cnt  <= byte_cnt + add_bytes;
      frame_cnt <= frame_cnt + add_frame;
      if (busy && rpt_ready) begin
        shreg <= shreg << 8;
        idx   <= idx + IDX_W'(1);
        if (is_last) busy <= 1'b0;
      end
    end
  end

  assign rpt_data  = shreg[REP_W-1 -: 8];
  assign rpt_valid = busy;
  assign rpt_last  = busy & is_last;

endmodule

// File: rtl/stream_stat_mon_chk.sv
module stream_stat_mon_chk (
  input logic       clk,
  input logic       rst,
  input logic       trigger,
  input logic [7:0] rpt_data,
  input logic       rpt_valid,
  input logic       rpt_ready,
  input logic       rpt_last
);

  a_r8_hold_stalled: assert property (@(posedge clk) disable iff (rst)
    rpt_valid && !rpt_ready |=> rpt_valid && $stable(rpt_data) && $stable(rpt_last));

  a_r5_last_needs_valid: assert property (@(posedge clk) disable iff (rst)
    rpt_last |-> rpt_valid);

  a_r5_ends_after_last: assert property (@(posedge clk) disable iff (rst)
    rpt_valid && rpt_ready && rpt_last |=> !rpt_valid);

  a_r9_starts_on_trigger: assert property (@(posedge clk) disable iff (rst)
    trigger && !rpt_valid |=> rpt_valid);

  a_r7_no_early_stop: assert property (@(posedge clk) disable iff (rst)
    rpt_valid && !(rpt_ready && rpt_last) |=> rpt_valid);

endmodule

bind stream_stat_mon stream_stat_mon_chk u_chk (
  .clk(clk), .rst(rst), .trigger(trigger), .rpt_data(rpt_data),
  .rpt_valid(rpt_valid), .rpt_ready(rpt_ready), .rpt_last(rpt_last)
);

// File: tb/stream_stat_mon_bench.sv
module stream_stat_mon_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  mon_keep = '0;
  logic        mon_valid = 1'b0, mon_ready = 1'b0, mon_last = 1'b0;
  logic [15:0] tag = '0;
  logic        trigger = 1'b0;
  logic [7:0]  rpt_data;
  logic        rpt_valid, rpt_ready = 1'b0, rpt_last;

  int n_tests = 0, n_fail = 0;
  longint exp_b = 0, exp_f = 0;
  longint snap_b, snap_f;
  bit done = 0;

  always #5 clk = ~clk;

  stream_stat_mon u_stream_stat_mon (
    .clk(clk), .rst(rst), .mon_keep(mon_keep), .mon_valid(mon_valid),
    .mon_ready(mon_ready), .mon_last(mon_last), .tag(tag), .trigger(trigger),
    .rpt_data(rpt_data), .rpt_valid(rpt_valid), .rpt_ready(rpt_ready),
    .rpt_last(rpt_last)
  );

  task automatic check(string req, string what, longint act, longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic beat(input logic [7:0] k, input logic v, input logic r, input logic l);
    @(negedge clk);
    mon_keep = k; mon_valid = v; mon_ready = r; mon_last = l;
    if (v && r) begin
      exp_b += $countones(k);
      if (l) exp_f++;
    end
    @(posedge clk); #1;
    mon_valid = 0; mon_ready = 0; mon_last = 0; mon_keep = '0;
  endtask

  task automatic fire(input logic [15:0] t, input bit with_beat);
    @(negedge clk);
    tag = t; trigger = 1;
    snap_b = exp_b; snap_f = exp_f;
    exp_b = 0; exp_f = 0;
    if (with_beat) begin
      mon_keep = 8'hFF; mon_valid = 1; mon_ready = 1; mon_last = 1;
      exp_b = 8; exp_f = 1;
    end
    @(posedge clk); #1;
    trigger = 0; mon_valid = 0; mon_ready = 0; mon_last = 0; mon_keep = '0;
    @(negedge clk);
    check("R9", "valid after trigger", rpt_valid, 1);
  endtask

  task automatic collect(input logic [15:0] t, input longint b, input longint f, input bit stall);
    logic [79:0] img;
    int i, cyc;
    img = {t, b[31:0], f[31:0]};
    i = 0; cyc = 0;
    while (i < 10 && cyc < 100) begin
      @(negedge clk);
      rpt_ready = stall ? (cyc % 3 != 0) : 1'b1;
      check("R5", "report valid", rpt_valid, 1);
      check(stall ? "R8" : "R5", $sformatf("byte %0d", i), rpt_data, img[79 - 8*i -: 8]);
      check("R5", $sformatf("last at byte %0d", i), rpt_last, (i == 9));
      if (rpt_ready) i++;
      cyc++;
      @(posedge clk); #1;
      rpt_ready = 0;
    end
    @(negedge clk);
    check("R5", "valid low after report", rpt_valid, 0);
  endtask

  task automatic t_reset_state;
    check("R1", "valid at reset", rpt_valid, 0);
    check("R1", "last at reset", rpt_last, 0);
    fire(16'hA001, 0);
    collect(16'hA001, snap_b, snap_f, 0);
    check("R1", "zero bytes after reset", snap_b, 0);
  endtask

  task automatic t_counting;
    beat(8'hFF, 1, 1, 0);
    beat(8'h01, 1, 1, 1);
    beat(8'hFF, 1, 0, 1);   // R3 valid only
    beat(8'hFF, 0, 1, 1);   // R3 ready only
    beat(8'h5A, 1, 1, 0);
    beat(8'h00, 1, 1, 1);   // R4 empty last beat
    beat(8'h80, 1, 1, 1);
    fire(16'hB2C3, 0);
    check("R2", "byte total", snap_b, 8 + 1 + 4 + 0 + 1);
    check("R4", "frame total", snap_f, 3);
    collect(16'hB2C3, snap_b, snap_f, 0);
  endtask

  task automatic t_trigger_cycle;
    beat(8'h0F, 1, 1, 1);
    fire(16'h0C0D, 1);
    check("R6", "old period bytes", snap_b, 4);
    collect(16'h0C0D, snap_b, snap_f, 0);
    fire(16'h0C0E, 0);
    check("R6", "new period bytes", snap_b, 8);
    check("R6", "new period frames", snap_f, 1);
    collect(16'h0C0E, snap_b, snap_f, 0);
  endtask

  task automatic t_busy_trigger;
    beat(8'h03, 1, 1, 1);
    fire(16'hD00D, 0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      rpt_ready = 0; trigger = 1; tag = 16'hEEEE;
      mon_keep = 8'h0F; mon_valid = 1; mon_ready = 1; mon_last = (k == 2);
      exp_b += 4; if (k == 2) exp_f++;
      @(posedge clk); #1;
      trigger = 0; mon_valid = 0; mon_ready = 0; mon_last = 0;
    end
    collect(16'hD00D, snap_b, snap_f, 1);
    @(negedge clk);
    check("R7", "no extra report", rpt_valid, 0);
    fire(16'hD00E, 0);
    check("R7", "bytes kept through ignored trigger", snap_b, 12);
    check("R7", "frames kept through ignored trigger", snap_f, 1);
    collect(16'hD00E, snap_b, snap_f, 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    t_reset_state;
    t_counting;
    t_trigger_cycle;
    t_busy_trigger;
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule